// File: doc/BRIEF.md
# Audio Stream Drift Compensator

This block joins a packet-based audio writer to a sample-rate audio reader whose clocks drift slowly apart. Stereo samples, left and right together in one word, go into a ring that holds exactly two packets. The reader drains one packet while the writer fills the other. The block never sends rate feedback to the writer and never resamples. It keeps the write-to-read phase steady by adding or removing one whole sample from the output stream.

A microsecond timer starts when the writer completes the packet that fills the second half of the ring. The timer stops when the reader wraps past the end of that half. Because of this, one interval is measured for every two packet periods. The first interval after reset is stored as the reference. Each later interval is compared with it in signed arithmetic. If the interval has grown by more than the threshold, the writer is ahead, and the next requested sample is skipped. If it has shrunk by more than the threshold, the reader is ahead, and the next request returns the previous output again. The default threshold is 20 µs, just under one 48 kHz sample period.

Top module: `drift_comp`

## Requirements
- R1: Samples written in order across the two ring halves (first-half packet, then second-half packet) are returned in the same order by successive read requests. Each request updates `rd_data` at the clock edge where `rd_req` is high.
- R2: After a synchronous reset, `rd_data` is zero and no correction is pending.
- R3: The first interval measured after reset becomes the reference and causes no correction. The interval runs from the packet-done strobe that completes the second ring half to the read request that wraps the read position, and counts ticks.
- R4: If the measured interval minus the reference is greater than `THRESH`, the next read request skips one buffered sample. Both channels are skipped together, so `rd_data` shows the sample after the one that would have come next.
- R5: If the measured interval minus the reference is less than `-THRESH`, the next read request repeats the last output word and does not advance the read position.
- R6: A difference of exactly `+THRESH` or `-THRESH`, or anything between them, causes no correction.
- R7: A correction never changes the stored reference. Later intervals are still compared against the first one.
- R8: The timer saturates at its maximum value and does not wrap. An interval longer than the counter range therefore counts as a large positive drift.
- R9: A synchronous reset discards the reference. The next full-ring measurement becomes the new reference.
- R10: At most one sample is added or removed per measurement. All reads after the corrected one follow the ring order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write one stereo word into the current packet |
| wr_data | input | 2*SW | Stereo word, left channel in the upper half |
| wr_pkt_done | input | 1 | Current packet complete; switches to the other ring half |
| rd_req | input | 1 | Sample request from the serializer |
| rd_data | output | 2*SW | Registered output stereo word |

## Verification
The bench builds the block with a four-sample packet, one tick per clock cycle, a threshold of 3 and a 12-bit timer. With one tick per cycle, the measured interval is exactly the idle gap plus two cycles per read. Every gap the bench chooses therefore sets a known drift, including the exact ±3 boundaries. With a 12-bit timer, the bench can reach the saturation case in about four thousand cycles, using a gap that would wrap back onto the reference if the counter were allowed to wrap.

// File: rtl/drift_pkg.sv
package drift_pkg;
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_DROP = 2'd1,
        ADJ_INS  = 2'd2
    } adj_e;
endpackage

// File: rtl/drift_ring.sv
module drift_ring #(
    parameter int SW  = 16,
    parameter int PKT = 48
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_valid,
    input  logic [2*SW-1:0]               wr_data,
    input  logic                          wr_pkt_done,
    input  logic [$clog2(2*PKT)-1:0]      rd_addr,
    output logic [2*SW-1:0]               rd_word,
    output logic                          full_o
);
    localparam int DEPTH = 2 * PKT;
    localparam int AW    = $clog2(DEPTH);
    localparam int IW    = (PKT > 1) ? $clog2(PKT) : 1;

    typedef struct packed {
        logic          half;
        logic [IW-1:0] idx;
    } wst_t;

    wst_t st_d, st_q;
    logic [2*SW-1:0] mem [DEPTH];
    logic [AW-1:0]   wr_addr;

    assign wr_addr = (st_q.half ? AW'(PKT) : AW'(0)) + AW'(st_q.idx);

    always_comb begin
        st_d = st_q;
        if (wr_pkt_done) begin
            st_d.half = ~st_q.half;
            st_d.idx  = '0;
        end else if (wr_valid && (int'(st_q.idx) < PKT - 1)) begin
            st_d.idx = st_q.idx + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_valid && !wr_pkt_done) mem[wr_addr] <= wr_data;
    end

    assign rd_word = mem[rd_addr];
    assign full_o  = wr_pkt_done && st_q.half;

    assert_widx_range_R1: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.idx) < PKT);
    assert_half_flip_R1: assert property (@(posedge clk) disable iff (rst)
        wr_pkt_done |=> st_q.half != $past(st_q.half));
endmodule

// File: rtl/drift_timer.sv
module drift_timer #(
    parameter int TW       = 13,
    parameter int TICK_DIV = 50
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    output logic [TW-1:0] count_o,
    output logic          run_o
);
    localparam logic [TW-1:0] CMAX = {TW{1'b1}};
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] div;
        logic [TW-1:0] cnt;
        logic          run;
    } tst_t;

    tst_t st_d, st_q;
    logic tick;

    generate
        if (TICK_DIV == 1) begin : g_fast
            assign tick = 1'b1;
        end else begin : g_div
            assign tick = (int'(st_q.div) == TICK_DIV - 1);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
            st_d.div = '0;
        end else if (stop) begin
            st_d.run = 1'b0;
        end else if (st_q.run) begin
            if (TICK_DIV > 1) st_d.div = tick ? '0 : st_q.div + DW'(1);
            if (tick && st_q.cnt != CMAX) st_d.cnt = st_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign run_o   = st_q.run;

    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.run && st_q.cnt == CMAX && !start) |=> st_q.cnt == CMAX);
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.run && !start) |=> st_q.cnt >= $past(st_q.cnt));
endmodule

// File: rtl/drift_comp.sv
module drift_comp
    import drift_pkg::*;
#(
    parameter int SW       = 16,
    parameter int PKT      = 48,
    parameter int TW       = 13,
    parameter int TICK_DIV = 50,
    parameter int THRESH   = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_valid,
    input  logic [2*SW-1:0] wr_data,
    input  logic            wr_pkt_done,
    input  logic            rd_req,
    output logic [2*SW-1:0] rd_data
);
    localparam int DEPTH = 2 * PKT;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0]   ptr;
        logic [2*SW-1:0] out;
        adj_e            pend;
        logic [TW-1:0]   ref_v;
        logic            ref_ok;
    } st_t;

    st_t st_d, st_q;
    logic [AW-1:0]   rd_addr;
    logic [2*SW-1:0] rd_word;
    logic            full;
    logic            t_stop;
    logic [TW-1:0]   t_count;
    logic            t_run;
    logic [AW:0]     ptr_sum;
    logic            wrap;
    logic signed [TW+1:0] diff;

    drift_ring #(.SW(SW), .PKT(PKT)) u_ring (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_pkt_done(wr_pkt_done),
        .rd_addr(rd_addr), .rd_word(rd_word), .full_o(full)
    );

    drift_timer #(.TW(TW), .TICK_DIV(TICK_DIV)) u_tmr (
        .clk(clk), .rst(rst), .start(full), .stop(t_stop),
        .count_o(t_count), .run_o(t_run)
    );

    always_comb begin
        st_d    = st_q;
        rd_addr = st_q.ptr;
        ptr_sum = {1'b0, st_q.ptr} + (AW+1)'(1);
        if (st_q.pend == ADJ_DROP) begin
            rd_addr = (int'(st_q.ptr) == DEPTH - 1) ? '0 : st_q.ptr + AW'(1);
            ptr_sum = {1'b0, st_q.ptr} + (AW+1)'(2);
        end
        wrap   = rd_req && (st_q.pend != ADJ_INS) && (int'(ptr_sum) >= DEPTH);
        t_stop = wrap && t_run && !full;
        diff   = $signed({2'b00, t_count}) - $signed({2'b00, st_q.ref_v});

        if (rd_req) begin
            if (st_q.pend == ADJ_INS) begin
                st_d.out = st_q.out;
            end else begin
                st_d.out = rd_word;
                st_d.ptr = wrap ? AW'(int'(ptr_sum) - DEPTH) : AW'(ptr_sum);
            end
            st_d.pend = ADJ_NONE;
        end

        if (t_stop) begin
            if (!st_q.ref_ok) begin
                st_d.ref_v  = t_count;
                st_d.ref_ok = 1'b1;
            end else if (diff > (TW+2)'(THRESH)) begin
                st_d.pend = ADJ_DROP;
            end else if (diff < -(TW+2)'(THRESH)) begin
                st_d.pend = ADJ_INS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{ptr: '0, out: '0, pend: ADJ_NONE, ref_v: '0, ref_ok: 1'b0};
        else     st_q <= st_d;
    end

    assign rd_data = st_q.out;

    assert_ptr_range_R1: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.ptr) < DEPTH);
    assert_no_adj_unref_R3: assert property (@(posedge clk) disable iff (rst)
        !st_q.ref_ok |-> st_q.pend == ADJ_NONE);
    assert_drop_step_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && st_q.pend == ADJ_DROP) |=>
        int'(st_q.ptr) == (int'($past(st_q.ptr)) + 2) % DEPTH);
    assert_ins_repeat_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && st_q.pend == ADJ_INS) |=> $stable(rd_data) && $stable(st_q.ptr));
    assert_ref_hold_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.ref_ok |=> $stable(st_q.ref_v));
    assert_one_adj_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && st_q.pend != ADJ_NONE && !t_stop) |=> st_q.pend == ADJ_NONE);
endmodule

// File: tb/sim_drift_comp.sv
module sim_drift_comp;
    localparam int SW = 16, PKT = 4, TW = 12, THR = 3;
    localparam int NV = 8;
    localparam int V_GAP [NV] = '{10, 12, 13, 14, 12, 6, 8, 7};
    localparam int V_ADJ [NV] = '{0, 0, 0, 1, 0, 2, 0, 0};

    logic clk = 1'b0, rst = 1'b1;
    logic wr_valid = 1'b0, wr_pkt_done = 1'b0, rd_req = 1'b0;
    logic [2*SW-1:0] wr_data = '0;
    logic [2*SW-1:0] rd_data;

    int checks = 0, errors = 0, rn = 0, pend = 0;
    logic [2*SW-1:0] last = '0;
    bit done = 1'b0;

    drift_comp #(.SW(SW), .PKT(PKT), .TW(TW), .TICK_DIV(1), .THRESH(THR)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_pkt_done(wr_pkt_done), .rd_req(rd_req), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    function automatic logic [2*SW-1:0] word(int r, int a);
        return {16'(r * 16 + a), 16'(16'hA000 + r * 16 + a)};
    endfunction

    task automatic check(logic [2*SW-1:0] exp, string req);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic rd_one(logic [2*SW-1:0] exp, string req);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        check(exp, req);
        last = exp;
    endtask

    // One measurement cycle; p is the correction expected from the previous one.
    task automatic round(int gap, int p, string req);
        rn++;
        for (int a = 0; a < 2 * PKT; a++) begin
            @(negedge clk) begin wr_valid = 1'b1; wr_data = word(rn, a); end
            @(negedge clk) wr_valid = 1'b0;
            if (a % PKT == PKT - 1) begin
                @(negedge clk) wr_pkt_done = 1'b1;
                @(negedge clk) wr_pkt_done = 1'b0;
            end
        end
        repeat (gap) @(negedge clk);
        if (p == 1) begin
            rd_one(word(rn, 1), {req, " R4 drop"});
            for (int a = 2; a < 2 * PKT; a++) rd_one(word(rn, a), {req, " R10"});
        end else if (p == 2) begin
            rd_one(last, {req, " R5 insert"});
            for (int a = 0; a < 2 * PKT; a++) rd_one(word(rn, a), {req, " R10"});
        end else begin
            for (int a = 0; a < 2 * PKT; a++) rd_one(word(rn, a), {req, " R1 R6"});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check('0, "R2 reset");
        rst = 1'b0;
        // Table: row 0 is the reference (R3); rows 1,2 and 7 cover R6 incl. +/-3;
        // row 3 drifts +4 (R4), row 5 drifts -4 (R5); each row's data checks the previous row.
        for (int i = 0; i < NV; i++) begin
            round(V_GAP[i], pend, $sformatf("row%0d R3 R7", i));
            pend = V_ADJ[i];
        end
        // R8: unbounded interval would be reference+4096 and wrap onto it; saturation gives drop.
        round(4096 + 10, pend, "R8 sat");
        round(12, 1, "R8 drop after saturation");
        // R9: reset discards the reference.
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check('0, "R2 R9 reset again");
        last = '0;
        round(30, 0, "R9 new reference");
        round(30, 0, "R9 equal to new reference");
        round(10, 0, "R9 no drop vs old reference");
        round(30, 2, "R9 insert vs new reference");
        round(30, 0, "R10 after insert");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule